// File: doc/BRIEF.md
# Two-Source Prioritized Interrupt Latch

This block holds the interrupt requests of a small microcontroller core and decides when one of them is taken. There are two sources. The first is an external pin: it is synchronized to the clock, and its leading edge latches a pin request. The second is a one-cycle overflow pulse from a timer/counter, which latches a timer request. A single global enable flag, driven by set-enable and clear-enable strobes from the instruction decoder, gates both sources.

An interrupt can be taken only on a cycle where the core marks the end of an instruction. At that point, if the delayed enable is high and a request is pending, `take_o` is raised for that cycle. `take_src_o` names the source, and the block clears both the serviced request and the enable. The enable reaches the take logic through a register that loads only at instruction boundaries, so a newly set enable acts one instruction later.

The pin request flag, the timer request flag and the synchronized pin level are exposed as status bits. This lets the pin serve as an extra latched input. A halt-mode disable input forces the pin path inactive.

Top module: `dual_irq_latch`

## Requirements
- R1: The pin is active-high by default. A 0-to-1 change of the gated, synchronized pin level sets `pin_req_o` two clock edges after the edge where the pin is first sampled high. The flag then stays set after the pin returns low.
- R2: A high `tmr_evt_i` at a clock edge sets `tmr_req_o` from that edge on.
- R3: `take_o` is high in a cycle only when `cyc_end_i` is high, the delayed enable is 1, and at least one request flag is set. It is combinational in that cycle.
- R4: At the clock edge that ends a take cycle, the serviced request flag and the enable flag are cleared. No take occurs in the cycle that follows.
- R5: The delayed enable loads the enable flag only on edges where `cyc_end_i` is high. After a set-enable, the first cycle-end cannot take; the second can.
- R6: While enable is 0, a set request flag keeps its value. It is taken once enable has propagated.
- R7: When both flags are set at a take, `take_src_o` is 0 (pin) and `tmr_req_o` stays 1. Timer takes report `take_src_o` = 1.
- R8: On each request flag and on the enable flag, a set in the same cycle as a clear wins.
- R9: `pin_lvl_o` shows the pin level after two synchronizer flops, gated by `io_dis_i`.
- R10: While `io_dis_i` is high, `pin_lvl_o` is 0 and no new pin request is latched. If the pin is still high when the disable is released, the resulting 0-to-1 change of the gated level counts as a leading edge.
- R11: An active-low asynchronous reset clears the synchronizer, the request flags, the enable and the delayed enable. All outputs are 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | External interrupt pin, asynchronous |
| io_dis_i | input | 1 | Halt-mode disable of the pin path |
| tmr_evt_i | input | 1 | Timer/counter overflow pulse |
| en_set_i | input | 1 | Set-enable strobe from the decoder |
| en_clr_i | input | 1 | Clear-enable strobe from the decoder |
| cyc_end_i | input | 1 | Instruction-cycle end strobe |
| take_o | output | 1 | Interrupt taken this cycle |
| take_src_o | output | 1 | Source of the take: 0 pin, 1 timer |
| pin_req_o | output | 1 | Pin request flag |
| tmr_req_o | output | 1 | Timer request flag |
| pin_lvl_o | output | 1 | Synchronized, gated pin level |

## Verification
The hardest state to reach is a pin take while a timer request is also pending, with the enable timing fixed by the delay register. Both flags must be set while enable is off, then set-enable and two cycle-ends must follow. A directed sequence builds this state and then checks that the timer request survives and is taken after re-enable. Constrained-random cycles then mix strobes with pin edges that land in the same cycle as takes, set/clear clashes, and disable windows. Each cycle is compared with a reference model in the bench.

// File: rtl/dual_irq_pkg.sv
package dual_irq_pkg;
  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  typedef enum logic [SRC_W-1:0] {
    SRC_PIN = 1'b0,
    SRC_TMR = 1'b1
  } irq_src_e;
endpackage

// File: rtl/dual_irq_pin_sync.sv
module dual_irq_pin_sync #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          ACT_HIGH    = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic io_dis_i,
  output logic level_o,
  output logic lead_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   pin_act;

  assign pin_act = ACT_HIGH ? pin_i : ~pin_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_act};
  end

  // gated level, so release of io_dis with pin high yields an edge
  assign level_o = sync_q[SYNC_STAGES-1] & ~io_dis_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_o;
  end

  assign lead_o = level_o & ~prev_q;
endmodule

// File: rtl/dual_irq_req_flag.sv
module dual_irq_req_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= set_i | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/dual_irq_en_ctl.sv
module dual_irq_en_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic take_i,
  input  logic bound_i,
  output logic en_dly_o
);
  logic en_q;
  logic en_dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= set_i | (en_q & ~(clr_i | take_i));
  end

  // one instruction of delay: load only on boundaries
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_dly_q <= 1'b0;
    else if (bound_i) en_dly_q <= en_q & ~take_i;
  end

  assign en_dly_o = en_dly_q;
endmodule

// File: rtl/dual_irq_take_arb.sv
module dual_irq_take_arb #(
  parameter int unsigned NUM_SRC = 2,
  localparam int unsigned SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               en_i,
  input  logic               bound_i,
  output logic               take_o,
  output logic [SRC_W-1:0]   src_o,
  output logic [NUM_SRC-1:0] ack_o
);
  logic [SRC_W-1:0] win;

  // lowest index has priority
  always_comb begin
    win = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) win = SRC_W'(i);
    end
  end

  assign take_o = bound_i & en_i & (|req_i);
  assign src_o  = win;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_ack
    assign ack_o[g] = take_o & (win == SRC_W'(g));
  end
endmodule

// File: rtl/dual_irq_latch.sv
module dual_irq_latch
  import dual_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter bit          PIN_ACT_HIGH = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic io_dis_i,
  input  logic tmr_evt_i,
  input  logic en_set_i,
  input  logic en_clr_i,
  input  logic cyc_end_i,
  output logic take_o,
  output logic take_src_o,
  output logic pin_req_o,
  output logic tmr_req_o,
  output logic pin_lvl_o
);
  logic               pin_lead;
  logic               en_dly;
  logic [NUM_SRC-1:0] req_set;
  logic [NUM_SRC-1:0] req_q;
  logic [NUM_SRC-1:0] ack;
  logic [SRC_W-1:0]   src;

  dual_irq_pin_sync #(
    .SYNC_STAGES(SYNC_STAGES),
    .ACT_HIGH   (PIN_ACT_HIGH)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (pin_i),
    .io_dis_i(io_dis_i),
    .level_o (pin_lvl_o),
    .lead_o  (pin_lead)
  );

  assign req_set[SRC_PIN] = pin_lead;
  assign req_set[SRC_TMR] = tmr_evt_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_req
    dual_irq_req_flag u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (req_set[g]),
      .clr_i (ack[g]),
      .flag_o(req_q[g])
    );
  end

  dual_irq_take_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .req_i  (req_q),
    .en_i   (en_dly),
    .bound_i(cyc_end_i),
    .take_o (take_o),
    .src_o  (src),
    .ack_o  (ack)
  );

  dual_irq_en_ctl u_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (en_set_i),
    .clr_i   (en_clr_i),
    .take_i  (take_o),
    .bound_i (cyc_end_i),
    .en_dly_o(en_dly)
  );

  assign take_src_o = src[0];
  assign pin_req_o  = req_q[SRC_PIN];
  assign tmr_req_o  = req_q[SRC_TMR];
endmodule

// File: rtl/dual_irq_latch_chk.sv
module dual_irq_latch_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic io_dis_i,
  input logic tmr_evt_i,
  input logic cyc_end_i,
  input logic take_o,
  input logic take_src_o,
  input logic pin_req_o,
  input logic tmr_req_o
);
  // R3
  take_at_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> cyc_end_i);
  // R3
  take_has_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (pin_req_o | tmr_req_o));
  // R7
  pin_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && pin_req_o) |-> !take_src_o);
  // R7
  tmr_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !take_src_o && tmr_req_o) |=> tmr_req_o);
  // R4
  no_double_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);
  // R6
  pin_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_req_o && !(take_o && !take_src_o)) |=> pin_req_o);
  // R2
  tmr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_evt_i |=> tmr_req_o);
  // R10
  dis_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pin_req_o) |-> $past(!io_dis_i));
endmodule

bind dual_irq_latch dual_irq_latch_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .io_dis_i  (io_dis_i),
  .tmr_evt_i (tmr_evt_i),
  .cyc_end_i (cyc_end_i),
  .take_o    (take_o),
  .take_src_o(take_src_o),
  .pin_req_o (pin_req_o),
  .tmr_req_o (tmr_req_o)
);

// File: tb/dual_irq_latch_tb.sv
`timescale 1ns/1ps
module dual_irq_latch_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic pin_i = 1'b0, io_dis_i = 1'b0, tmr_evt_i = 1'b0;
  logic en_set_i = 1'b0, en_clr_i = 1'b0, cyc_end_i = 1'b0;
  logic take_o, take_src_o, pin_req_o, tmr_req_o, pin_lvl_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state
  logic m_s1, m_s2, m_prev, m_ri, m_rt, m_en, m_end;

  always #2.5 clk_i = ~clk_i;

  dual_irq_latch dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .io_dis_i(io_dis_i),
    .tmr_evt_i(tmr_evt_i), .en_set_i(en_set_i), .en_clr_i(en_clr_i),
    .cyc_end_i(cyc_end_i), .take_o(take_o), .take_src_o(take_src_o),
    .pin_req_o(pin_req_o), .tmr_req_o(tmr_req_o), .pin_lvl_o(pin_lvl_o)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic m_clear();
    {m_s1, m_s2, m_prev, m_ri, m_rt, m_en, m_end} = '0;
  endtask

  function automatic logic m_lvl();
    return m_s2 & ~io_dis_i;
  endfunction

  function automatic logic m_take();
    return cyc_end_i & m_end & (m_ri | m_rt);
  endfunction

  task automatic compare();
    chk(pin_req_o, m_ri, "R1 pin_req");
    chk(tmr_req_o, m_rt, "R2 tmr_req");
    chk(take_o, m_take(), "R3 take");
    if (m_take()) chk(take_src_o, ~m_ri, "R7 src");
    chk(pin_lvl_o, m_lvl(), "R9 pin_lvl");
  endtask

  task automatic m_step();
    logic g, lead, tk, src;
    if (!rst_ni) begin m_clear(); return; end
    g = m_lvl(); lead = g & ~m_prev; tk = m_take(); src = ~m_ri;
    if (cyc_end_i) m_end = m_en & ~tk;
    m_en = en_set_i | (m_en & ~en_clr_i & ~tk);
    m_ri = lead | (m_ri & ~(tk & ~src));
    m_rt = tmr_evt_i | (m_rt & ~(tk & src));
    m_prev = g; m_s2 = m_s1; m_s1 = pin_i;
  endtask

  task automatic drive(input logic p, d, t, s, c, e);
    pin_i = p; io_dis_i = d; tmr_evt_i = t;
    en_set_i = s; en_clr_i = c; cyc_end_i = e;
    #1;
    compare();
  endtask

  task automatic adv();
    @(posedge clk_i);
    m_step();
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_clear();
    // R11 reset state
    drive(1, 0, 1, 1, 0, 1);
    repeat (3) adv();
    chk(take_o, 1'b0, "R11 take");
    chk(pin_req_o, 1'b0, "R11 pin_req");
    chk(tmr_req_o, 1'b0, "R11 tmr_req");
    chk(pin_lvl_o, 1'b0, "R11 pin_lvl");
    drive(0, 0, 0, 0, 0, 0);
    rst_ni = 1'b1;
    m_clear();
    adv();

    // R5 enable delay, timer source
    drive(0, 0, 1, 1, 0, 0); adv();
    drive(0, 0, 0, 0, 0, 1); chk(take_o, 1'b0, "R5 first boundary"); adv();
    drive(0, 0, 0, 0, 0, 1); chk(take_o, 1'b1, "R5 second boundary");
    chk(take_src_o, 1'b1, "R7 timer src"); adv();
    drive(0, 0, 0, 0, 0, 0); chk(tmr_req_o, 1'b0, "R4 tmr cleared");
    chk(take_o, 1'b0, "R4 no repeat"); adv();

    // R1 R9 latency, R7 clash
    drive(1, 0, 1, 1, 0, 0); adv();
    drive(1, 0, 0, 0, 0, 0); adv();
    chk(pin_lvl_o, 1'b1, "R9 level");
    chk(pin_req_o, 1'b0, "R1 not yet");
    adv();
    chk(pin_req_o, 1'b1, "R1 set");
    drive(0, 0, 0, 0, 0, 0); repeat (4) adv();
    chk(pin_req_o, 1'b1, "R1 held");
    drive(0, 0, 0, 0, 0, 1); adv();
    drive(0, 0, 0, 0, 0, 1);
    chk(take_o, 1'b1, "R7 take"); chk(take_src_o, 1'b0, "R7 pin wins"); adv();
    drive(0, 0, 0, 0, 0, 0);
    chk(tmr_req_o, 1'b1, "R7 timer pending"); chk(pin_req_o, 1'b0, "R4 pin cleared");
    repeat (6) begin drive(0, 0, 0, 0, 0, 1); chk(take_o, 1'b0, "R6 disabled"); adv(); end
    chk(tmr_req_o, 1'b1, "R6 held");
    drive(0, 0, 0, 1, 0, 0); adv();
    drive(0, 0, 0, 0, 0, 1); adv();
    drive(0, 0, 0, 0, 0, 1); chk(take_o, 1'b1, "R6 taken");
    chk(take_src_o, 1'b1, "R6 src"); adv();

    // R8 set beats clear on enable
    drive(0, 0, 1, 1, 1, 0); adv();
    drive(0, 0, 0, 0, 0, 1); adv();
    drive(0, 0, 0, 0, 0, 1); chk(take_o, 1'b1, "R8 enable kept"); adv();

    // R10 disable blocks, release counts as edge
    drive(1, 1, 0, 0, 0, 0); repeat (4) adv();
    chk(pin_lvl_o, 1'b0, "R10 level");
    chk(pin_req_o, 1'b0, "R10 no req");
    drive(1, 0, 0, 0, 0, 0); adv(); adv();
    chk(pin_req_o, 1'b1, "R10 release edge");
    drive(0, 0, 0, 1, 0, 0); adv();
    drive(0, 0, 0, 0, 0, 1); adv();
    drive(0, 0, 0, 0, 0, 1); adv();
    drive(0, 0, 0, 0, 0, 0); adv();

    // random phase, per-cycle model compare
    for (int i = 0; i < 6000; i++) begin
      logic p;
      p = (($urandom % 8) == 0) ? ~pin_i : pin_i;
      drive(p, ($urandom % 16) == 0, ($urandom % 10) == 0,
            ($urandom % 6) == 0, ($urandom % 10) == 0, ($urandom % 3) == 0);
      adv();
      if (i == 3000) begin
        rst_ni = 1'b0; #1;
        m_clear();
        chk(pin_req_o, 1'b0, "R11 midrun pin_req");
        chk(tmr_req_o, 1'b0, "R11 midrun tmr_req");
        adv();
        rst_ni = 1'b1;
      end
    end

    done = 1'b1;
    finish_run();
  end
endmodule